// File: doc/BRIEF.md
# Display Identification Fetch with Block Checksum Validation

This block fetches display identification data from an attached sink through a byte-read request port addressed to bus device 0x50. Each attempt starts by reading the extension count byte. Then, in order, it reads one 128-byte block, or two blocks when that count is nonzero, into a local buffer. Each block is checked on its own: the 8-bit wrapping sum of its 128 bytes must be zero.

A failed read or a bad block sum abandons the current attempt, and the whole sequence restarts from the extension count read. After the third failed attempt the block gives up and flags an error. After a clean fetch the block reads a compliance test request byte over a sideband register port. If the request asks for an identification-read test, it first writes the checksum byte of the last fetched block to the test checksum register, then writes an acknowledge code to the test response register. The result is reported as a single-cycle done or error pulse. The buffer remains readable through a combinational read port until the next start.

Top module: `edid_fetch`

## Requirements
- R1: After synchronous reset, rd_req, sb_req, done and error are all low.
- R2: Every attempt begins with one byte read from device 0x50 (rd_dev) at byte offset 126, the extension count.
- R3: When the extension count is zero, the attempt reads offsets 0 to 127 in increasing order. When it is nonzero, it reads offsets 0 to 255 in increasing order. A request holds its offset until rd_ack or rd_err.
- R4: A block whose 128 bytes do not sum to zero modulo 256 ends the attempt at that block's last byte. The blocks at offsets 0 to 127 and 128 to 255 are summed separately.
- R5: An rd_err response (bus NACK or timeout) ends the attempt at once. No further reads happen in that attempt.
- R6: A failed attempt is followed by a fresh attempt, up to 3 attempts in total. When the third attempt fails, error pulses and done does not.
- R7: After a clean fetch, one sideband read is made at address 0x218. If bit 2 of the returned byte is clear, done pulses and no sideband write is made.
- R8: If that bit 2 is set, the block first writes the byte at offset 127 of the last fetched block to address 0x261. It then writes 0x04 to address 0x260, and only then pulses done.
- R9: done and error are one-cycle pulses, exactly one per started run, and they are never high together.
- R10: After done, buf_data shows the byte fetched at offset buf_addr, and it keeps showing it while the block stays idle.
- R11: A start pulse while a fetch is in progress is ignored. The fetch neither restarts nor changes its read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| rd_req | output | 1 | Byte read request, held until a response |
| rd_dev | output | 7 | Bus device address of the read |
| rd_off | output | 8 | Byte offset of the read |
| rd_ack | input | 1 | Read response valid with data |
| rd_err | input | 1 | Read failed (NACK or timeout) |
| rd_data | input | 8 | Read data, valid with rd_ack |
| sb_req | output | 1 | Sideband request, held until sb_ack |
| sb_we | output | 1 | Sideband write (1) or read (0) |
| sb_addr | output | 12 | Sideband register address |
| sb_wdata | output | 8 | Sideband write data |
| sb_ack | input | 1 | Sideband response |
| sb_rdata | input | 8 | Sideband read data, valid with sb_ack |
| buf_addr | input | 8 | Buffer read offset |
| buf_data | output | 8 | Buffer byte at buf_addr (combinational) |
| done | output | 1 | One-cycle pulse on success |
| error | output | 1 | One-cycle pulse after the last failed attempt |

## Verification
The block consumes a read or sideband response at the same rising edge that presents it, and the next request shows up in that same cycle. The bench models both responders with a fixed latency. It logs every request at the moment it answers, then compares the full offset and sideband logs against a reference sequence built from the image and the injected failures. done and error are registered, so they rise one edge after the final response. The bench therefore samples them on falling edges, waits until one is seen, and allows several more cycles before it checks pulse counts. buf_data is combinational, so it is sampled 1 ns after buf_addr changes, well clear of any clock edge.

// File: rtl/edid_pkg.sv
`timescale 1ns/1ps
package edid_pkg;
    localparam int BYTE_W    = 8;
    localparam int DEV_W     = 7;
    localparam int SB_ADDR_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_BLK,
        ST_ABORT,
        ST_SB_REQ,
        ST_SB_CSUM,
        ST_SB_RESP
    } fetch_state_e;

    typedef struct packed {
        logic                 req;
        logic                 we;
        logic [SB_ADDR_W-1:0] addr;
        logic [BYTE_W-1:0]    data;
    } sb_cmd_t;

    function automatic logic is_sb_state(fetch_state_e s);
        return (s == ST_SB_REQ) || (s == ST_SB_CSUM) || (s == ST_SB_RESP);
    endfunction
endpackage

// File: rtl/edid_csum_acc.sv
`timescale 1ns/1ps
module edid_csum_acc import edid_pkg::*; #(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum,
    output logic [W-1:0] sum_next
);
    logic [W-1:0] acc_q;

    assign sum_next = acc_q + din;
    assign sum      = acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else if (add)   acc_q <= sum_next;
    end
endmodule

// File: rtl/edid_byte_store.sv
`timescale 1ns/1ps
module edid_byte_store import edid_pkg::*; #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/edid_fetch.sv
`timescale 1ns/1ps
module edid_fetch import edid_pkg::*; #(
    parameter int                   BLK_BYTES  = 128,
    parameter int                   MAX_BLKS   = 2,
    parameter int                   MAX_TRIES  = 3,
    parameter int                   EXT_IDX    = 126,
    parameter int                   OFF_W      = $clog2(BLK_BYTES * MAX_BLKS),
    parameter logic [DEV_W-1:0]     DEV_ADDR   = 7'h50,
    parameter logic [SB_ADDR_W-1:0] TREQ_ADDR  = 12'h218,
    parameter logic [SB_ADDR_W-1:0] TCSUM_ADDR = 12'h261,
    parameter logic [SB_ADDR_W-1:0] TRESP_ADDR = 12'h260,
    parameter int                   TREQ_BIT   = 2,
    parameter logic [BYTE_W-1:0]    ACK_CODE   = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 rd_req,
    output logic [DEV_W-1:0]     rd_dev,
    output logic [OFF_W-1:0]     rd_off,
    input  logic                 rd_ack,
    input  logic                 rd_err,
    input  logic [BYTE_W-1:0]    rd_data,
    output logic                 sb_req,
    output logic                 sb_we,
    output logic [SB_ADDR_W-1:0] sb_addr,
    output logic [BYTE_W-1:0]    sb_wdata,
    input  logic                 sb_ack,
    input  logic [BYTE_W-1:0]    sb_rdata,
    input  logic [OFF_W-1:0]     buf_addr,
    output logic [BYTE_W-1:0]    buf_data,
    output logic                 done,
    output logic                 error
);
    localparam int IDX_W    = $clog2(BLK_BYTES);
    localparam int TRY_W    = $clog2(MAX_TRIES + 1);
    localparam int DEPTH    = BLK_BYTES * MAX_BLKS;
    localparam int LAST_ONE = BLK_BYTES - 1;
    localparam int LAST_ALL = DEPTH - 1;

    fetch_state_e      state_q, state_d;
    logic [OFF_W-1:0]  off_q, off_d;
    logic              multi_q, multi_d;
    logic [TRY_W-1:0]  tries_q, tries_d;
    logic [BYTE_W-1:0] csum_q, csum_d;
    logic              done_q, done_d, error_q, error_d;
    logic              abort;
    logic              acc_add, acc_clr;
    logic [BYTE_W-1:0] acc_sum, acc_next;
    logic              blk_end, seq_end;
    logic [OFF_W-1:0]  last_off;
    sb_cmd_t           sb_cmd;
    logic              sb_unused;

    assign sb_unused = ^sb_rdata;

    assign blk_end  = (off_q[IDX_W-1:0] == IDX_W'(LAST_ONE));
    assign last_off = multi_q ? OFF_W'(LAST_ALL) : OFF_W'(LAST_ONE);
    assign seq_end  = (off_q == last_off);

    assign rd_req = (state_q == ST_EXT) || (state_q == ST_BLK);
    assign rd_dev = DEV_ADDR;
    assign rd_off = (state_q == ST_EXT) ? OFF_W'(EXT_IDX) : off_q;

    assign acc_add = (state_q == ST_BLK) && rd_ack && !rd_err;
    assign acc_clr = ((state_q == ST_EXT) && rd_ack && !rd_err) || (acc_add && blk_end);

    edid_csum_acc #(.W(BYTE_W)) u_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add),
        .din(rd_data), .sum(acc_sum), .sum_next(acc_next)
    );

    edid_byte_store #(.DEPTH(DEPTH), .AW(OFF_W)) u_store (
        .clk(clk), .wr_en(acc_add), .wr_addr(off_q), .wr_data(rd_data),
        .rd_addr(buf_addr), .rd_data(buf_data)
    );

    always_comb begin
        sb_cmd.req  = is_sb_state(state_q);
        sb_cmd.we   = (state_q == ST_SB_CSUM) || (state_q == ST_SB_RESP);
        sb_cmd.addr = TREQ_ADDR;
        sb_cmd.data = '0;
        if (state_q == ST_SB_CSUM) begin
            sb_cmd.addr = TCSUM_ADDR;
            sb_cmd.data = csum_q;
        end else if (state_q == ST_SB_RESP) begin
            sb_cmd.addr = TRESP_ADDR;
            sb_cmd.data = ACK_CODE;
        end
    end

    assign sb_req   = sb_cmd.req;
    assign sb_we    = sb_cmd.we;
    assign sb_addr  = sb_cmd.addr;
    assign sb_wdata = sb_cmd.data;

    always_comb begin
        state_d = state_q;
        off_d   = off_q;
        multi_d = multi_q;
        tries_d = tries_q;
        csum_d  = csum_q;
        done_d  = 1'b0;
        error_d = 1'b0;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_EXT;
                tries_d = '0;
            end
            ST_EXT: begin
                if (rd_err) abort = 1'b1;
                else if (rd_ack) begin
                    multi_d = (rd_data != '0);
                    off_d   = '0;
                    state_d = ST_BLK;
                end
            end
            ST_BLK: begin
                if (rd_err) abort = 1'b1;
                else if (rd_ack) begin
                    if (blk_end && (acc_next != '0)) abort = 1'b1;
                    else if (seq_end) begin
                        csum_d  = rd_data;
                        state_d = ST_SB_REQ;
                    end else off_d = off_q + 1'b1;
                end
            end
            ST_ABORT: state_d = ST_EXT;
            ST_SB_REQ: if (sb_ack) begin
                if (sb_rdata[TREQ_BIT]) state_d = ST_SB_CSUM;
                else begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_SB_CSUM: if (sb_ack) state_d = ST_SB_RESP;
            ST_SB_RESP: if (sb_ack) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
                state_d = ST_IDLE;
                error_d = 1'b1;
            end else begin
                tries_d = tries_q + 1'b1;
                state_d = ST_ABORT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            off_q   <= '0;
            multi_q <= 1'b0;
            tries_q <= '0;
            csum_q  <= '0;
            done_q  <= 1'b0;
            error_q <= 1'b0;
        end else begin
            state_q <= state_d;
            off_q   <= off_d;
            multi_q <= multi_d;
            tries_q <= tries_d;
            csum_q  <= csum_d;
            done_q  <= done_d;
            error_q <= error_d;
        end
    end

    assign done  = done_q;
    assign error = error_q;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && !rd_err) |=> (rd_req && $stable(rd_off)));
    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack && !rd_err) |=> (!rd_req || (rd_off != $past(rd_off))));
    assert_blk_start_R4: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_BLK) && (off_q[IDX_W-1:0] == '0)) |-> (acc_sum == '0));
    assert_error_last_try_R6: assert property (@(posedge clk) disable iff (rst)
        error |-> ($past(tries_q) == TRY_W'(MAX_TRIES - 1)));
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && sb_req));
    assert_sb_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (sb_req && !sb_ack) |=> (sb_req && $stable(sb_addr) && $stable(sb_wdata)));
    assert_sb_wr_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (sb_req && sb_we) |-> ((sb_addr == TCSUM_ADDR) || (sb_addr == TRESP_ADDR)));
    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && error));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_error_single_R9: assert property (@(posedge clk) disable iff (rst)
        error |=> !error);
endmodule

// File: tb/edid_fetch_bench.sv
`timescale 1ns/1ps
module edid_fetch_bench;
    localparam int RD_LAT = 1;
    localparam int SB_LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_req, rd_ack, rd_err;
    logic [6:0]  rd_dev;
    logic [7:0]  rd_off, rd_data;
    logic        sb_req, sb_we, sb_ack;
    logic [11:0] sb_addr;
    logic [7:0]  sb_wdata, sb_rdata;
    logic [7:0]  buf_addr = '0;
    logic [7:0]  buf_data;
    logic        done, error;

    always #5 clk = ~clk;

    edid_fetch u_edid_fetch (
        .clk(clk), .rst(rst), .start(start),
        .rd_req(rd_req), .rd_dev(rd_dev), .rd_off(rd_off),
        .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
        .sb_req(sb_req), .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
        .sb_ack(sb_ack), .sb_rdata(sb_rdata),
        .buf_addr(buf_addr), .buf_data(buf_data), .done(done), .error(error)
    );

    int tests = 0;
    int fails = 0;

    logic [7:0]  img [0:255];
    bit          err_map [0:1023];
    logic [7:0]  test_req;
    int          rd_log [0:1023];
    int          nlog;
    int          dev_bad;
    logic [11:0] sb_log_addr [0:7];
    logic        sb_log_we   [0:7];
    logic [7:0]  sb_log_data [0:7];
    int          nsb;
    int          n_done, n_err;

    int          exp_log [0:1023];
    int          exp_n;
    bit          exp_ok;
    int          exp_nb;

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // read responder
    initial begin
        int lat = 0;
        rd_ack = 0; rd_err = 0; rd_data = '0;
        forever begin
            @(posedge clk); #1;
            rd_ack = 0; rd_err = 0;
            if (rd_req) begin
                if (lat == RD_LAT) begin
                    if (nlog < 1024) begin
                        rd_log[nlog] = int'(rd_off);
                        if (err_map[nlog]) rd_err = 1;
                        else begin rd_ack = 1; rd_data = img[rd_off]; end
                    end
                    if (rd_dev != 7'h50) dev_bad++;
                    nlog++;
                    lat = 0;
                end else lat++;
            end else lat = 0;
        end
    end

    // sideband responder
    initial begin
        int lat = 0;
        sb_ack = 0; sb_rdata = '0;
        forever begin
            @(posedge clk); #1;
            sb_ack = 0;
            if (sb_req) begin
                if (lat == SB_LAT) begin
                    if (nsb < 8) begin
                        sb_log_addr[nsb] = sb_addr;
                        sb_log_we[nsb]   = sb_we;
                        sb_log_data[nsb] = sb_wdata;
                    end
                    nsb++;
                    sb_ack = 1;
                    sb_rdata = test_req;
                    lat = 0;
                end else lat++;
            end else lat = 0;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (done) n_done++;
            if (error) n_err++;
        end
    end

    task automatic make_img(logic [7:0] ext);
        logic [7:0] s0, s1;
        s0 = '0; s1 = '0;
        for (int i = 0; i < 256; i++) img[i] = 8'($urandom);
        img[126] = ext;
        for (int i = 0; i < 127; i++) s0 += img[i];
        for (int i = 128; i < 255; i++) s1 += img[i];
        img[127] = 8'(-s0);
        img[255] = 8'(-s1);
        for (int i = 0; i < 1024; i++) err_map[i] = 0;
    endtask

    task automatic model();
        bit ok;
        int nb;
        logic [7:0] s;
        exp_n = 0; exp_ok = 0; exp_nb = 1;
        for (int a = 0; a < 3 && !exp_ok; a++) begin
            exp_log[exp_n] = 126; ok = !err_map[exp_n]; exp_n++;
            if (ok) begin
                nb = (img[126] != 0) ? 2 : 1;
                for (int b = 0; b < nb && ok; b++) begin
                    s = '0;
                    for (int i = 0; i < 128 && ok; i++) begin
                        exp_log[exp_n] = b * 128 + i;
                        ok = !err_map[exp_n];
                        exp_n++;
                        s += img[b * 128 + i];
                    end
                    if (ok && s != 0) ok = 0;
                end
                if (ok) begin exp_ok = 1; exp_nb = nb; end
            end
        end
    endtask

    task automatic run_case(string name, bit extra_start);
        int cyc = 0;
        int bad = -1;
        int exp_sb;
        nlog = 0; nsb = 0; n_done = 0; n_err = 0; dev_bad = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (n_done == 0 && n_err == 0 && cyc < 20000) begin
            start = extra_start && (cyc == 60);
            @(negedge clk);
            cyc++;
        end
        start = 0;
        repeat (20) @(negedge clk);
        model();
        if (exp_ok) check(n_done == 1 && n_err == 0, "R6", {name, " done outcome"}, n_done, 1);
        else        check(n_err == 1 && n_done == 0, "R6", {name, " error outcome (R4/R5)"}, n_err, 1);
        check(n_done + n_err == 1, "R9", {name, " pulse count"}, n_done + n_err, 1);
        check(dev_bad == 0, "R2", {name, " device address"}, dev_bad, 0);
        for (int i = 0; i < exp_n && i < nlog; i++)
            if (bad < 0 && rd_log[i] != exp_log[i]) bad = i;
        check(nlog == exp_n, extra_start ? "R11" : "R3", {name, " read count"}, nlog, exp_n);
        check(bad < 0, "R3", {name, " read offset order"},
              (bad < 0) ? 0 : rd_log[bad], (bad < 0) ? 0 : exp_log[bad]);
        exp_sb = !exp_ok ? 0 : (test_req[2] ? 3 : 1);
        check(nsb == exp_sb, test_req[2] ? "R8" : "R7", {name, " sideband ops"}, nsb, exp_sb);
        if (exp_sb >= 1 && nsb >= 1)
            check(sb_log_addr[0] == 12'h218 && !sb_log_we[0], "R7", {name, " test request read"},
                  int'(sb_log_addr[0]), 'h218);
        if (exp_sb == 3 && nsb >= 3) begin
            check(sb_log_we[1] && sb_log_addr[1] == 12'h261 &&
                  sb_log_data[1] == img[exp_nb * 128 - 1], "R8", {name, " checksum write"},
                  int'(sb_log_data[1]), int'(img[exp_nb * 128 - 1]));
            check(sb_log_we[2] && sb_log_addr[2] == 12'h260 && sb_log_data[2] == 8'h04,
                  "R8", {name, " response write"}, int'(sb_log_data[2]), 4);
        end
        if (exp_ok) begin
            bad = -1;
            for (int i = 0; i < exp_nb * 128; i++) begin
                buf_addr = 8'(i); #1;
                if (bad < 0 && buf_data != img[i]) bad = i;
            end
            check(bad < 0, "R10", {name, " buffer contents"}, bad, -1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_ed01));
        nlog = 0; nsb = 0; n_done = 0; n_err = 0; dev_bad = 0;
        test_req = '0;
        for (int i = 0; i < 1024; i++) err_map[i] = 0;
        repeat (4) @(negedge clk);
        check(!rd_req && !sb_req && !done && !error, "R1", "reset outputs",
              int'({rd_req, sb_req, done, error}), 0);
        rst = 0;
        @(negedge clk);

        make_img(8'h00); test_req = 8'h00;
        run_case("single block, no test", 0);

        make_img(8'h01); test_req = 8'h04;
        run_case("two blocks, test set", 0);

        make_img(8'h00); test_req = 8'hFF;
        run_case("single block, test set", 0);

        make_img(8'h02); test_req = 8'hFB;
        run_case("two blocks, other bits only, restart ignored", 1);

        make_img(8'h01); img[200] ^= 8'h01; test_req = 8'h04;
        run_case("bad second block sum", 0);

        make_img(8'h00); err_map[0] = 1; test_req = 8'h04;
        run_case("nack on extension read", 0);

        make_img(8'h01); err_map[150] = 1; err_map[151 + 100] = 1; test_req = 8'h04;
        run_case("nacks in two attempts", 0);

        make_img(8'h00); err_map[5] = 1; err_map[7] = 1; err_map[8] = 1; test_req = 8'h00;
        run_case("three failed attempts", 0);

        for (int r = 0; r < 6; r++) begin
            make_img(($urandom % 2) ? 8'($urandom % 255 + 1) : 8'h00);
            test_req = 8'($urandom);
            for (int k = 0; k < 3; k++)
                if ($urandom % 3 == 0) err_map[$urandom % 600] = 1;
            if ($urandom % 4 == 0) img[$urandom % 256] ^= 8'h10;
            run_case("random", 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule